// File: doc/BRIEF.md
# Jump and Call Target Address Unit

This unit produces the next program-counter value for the jump and call forms of a small 8-bit controller with a 16-bit program space. For each request it takes the address of the instruction's first byte, the instruction length in bytes and a mode code. A single 16-bit operand word carries the destination, and the mode selects how that word is read. From these inputs the unit forms the fall-through address and the branch target. Both results are captured in one output register stage.

Three addressing modes are supported:

- **Long:** takes the whole operand word as the target.
- **Page-local:** keeps the upper five bits of the fall-through address and replaces the lower eleven bits with the operand's low field. The target therefore stays in the 2 KB page of the following instruction, not the page of the current one.
- **Offset:** adds a signed 8-bit displacement to the fall-through address.

Checking the branch condition, pushing return addresses and fetching from memory are done elsewhere in the pipeline.

Top module: `bta_target_gen`

## Requirements
- R1: While `rst_ni` is low, both `target_o` and `next_o` are 0 from the clock edge onward.
- R2: On a clock edge with `valid_i` high, `next_o` becomes (`pc_i` + `len_i`) modulo 65536. `len_i` is 1, 2 or 3.
- R3: With `mode_i` = 0 (long) and `valid_i` high, `target_o` becomes `operand_i` one edge later.
- R4: With `mode_i` = 1 (page-local), `target_o[10:0]` becomes `operand_i[10:0]`. `target_o[15:11]` becomes bits 15..11 of (`pc_i` + `len_i`), including when that sum crosses into a new 2 KB page.
- R5: With `mode_i` = 2 (offset), `target_o` becomes (`pc_i` + `len_i` + sign-extended `operand_i[7:0]`) modulo 65536. Displacements range from -128 to +127.
- R6: `operand_i[15:8]` has no effect on the result in offset mode. `operand_i[15:11]` has no effect on the result in page-local mode.
- R7: With `mode_i` = 3 (reserved), `target_o` becomes the same value as `next_o`, the fall-through address.
- R8: On an edge with `valid_i` low, `target_o` and `next_o` keep their values.
- R9: Results appear exactly one clock edge after the inputs are presented. There is no combinational path from the inputs to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the output register |
| pc_i | input | 16 | Address of the current instruction's first byte |
| len_i | input | 2 | Instruction length in bytes (1 to 3) |
| mode_i | input | 2 | 0 long, 1 page-local, 2 offset, 3 reserved |
| operand_i | input | 16 | Destination word or displacement |
| target_o | output | 16 | Registered branch target |
| next_o | output | 16 | Registered fall-through address |

## Verification
The bench builds the unit with its default widths: a 16-bit address, an 11-bit page field and an 8-bit displacement. With these widths, wrap-around at the top of the 64 KB space can be reached in a single step. Page crossings between the current and the following instruction are also reachable at every 2 KB boundary. Directed vectors place `pc_i` just below such boundaries and drive both extreme displacements. Random vectors fill junk into the operand bits that the selected mode ignores.

// File: rtl/bta_pkg.sv
package bta_pkg;
   typedef enum logic [1:0] {
      BTA_LONG = 2'd0,
      BTA_PAGE = 2'd1,
      BTA_OFFS = 2'd2,
      BTA_RSVD = 2'd3
   } bta_mode_e;
endpackage

// File: rtl/bta_seq_addr.sv
module bta_seq_addr #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 2
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] next_o
);
   if (LEN_W >= ADDR_W) begin : g_bad_len
      $error("bta_seq_addr: LEN_W must be narrower than ADDR_W");
   end

   localparam int PAD_W = ADDR_W - LEN_W;

   // Fall-through address; the sum wraps at the top of the space.
   always_comb next_o = pc_i + {{PAD_W{1'b0}}, len_i};
endmodule

// File: rtl/bta_rel_add.sv
module bta_rel_add #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 8
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] sum_o
);
   logic [ADDR_W-1:0] off_ext;

   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("bta_rel_add: OFF_W exceeds ADDR_W");
   end else if (OFF_W == ADDR_W) begin : g_full
      always_comb off_ext = off_i;
   end else begin : g_sext
      localparam int EXT_W = ADDR_W - OFF_W;
      always_comb off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
   end

   always_comb sum_o = base_i + off_ext;
endmodule

// File: rtl/bta_target_sel.sv
module bta_target_sel
   import bta_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 11
) (
   input  bta_mode_e         mode_i,
   input  logic [ADDR_W-1:0] next_i,
   input  logic [ADDR_W-1:0] long_i,
   input  logic [ADDR_W-1:0] rel_i,
   output logic [ADDR_W-1:0] target_o
);
   if (PAGE_W >= ADDR_W || PAGE_W < 1) begin : g_bad_page
      $error("bta_target_sel: PAGE_W must lie in 1..ADDR_W-1");
   end

   logic [ADDR_W-1:0] page_tgt;

   // Page bits come from the following instruction, not the current one.
   always_comb page_tgt = {next_i[ADDR_W-1:PAGE_W], long_i[PAGE_W-1:0]};

   always_comb begin
      unique case (mode_i)
         BTA_LONG: target_o = long_i;
         BTA_PAGE: target_o = page_tgt;
         BTA_OFFS: target_o = rel_i;
         default:  target_o = next_i;
      endcase
   end
endmodule

// File: rtl/bta_target_gen.sv
module bta_target_gen
   import bta_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 2,
   parameter int PAGE_W = 11,
   parameter int OFF_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] operand_i,
   output logic [ADDR_W-1:0] target_o,
   output logic [ADDR_W-1:0] next_o
);
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("bta_target_gen: OFF_W exceeds ADDR_W");
   end

   logic [ADDR_W-1:0] next_d;
   logic [ADDR_W-1:0] rel_d;
   logic [ADDR_W-1:0] tgt_d;
   logic [ADDR_W-1:0] next_q;
   logic [ADDR_W-1:0] tgt_q;

   bta_seq_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
      .pc_i  (pc_i),
      .len_i (len_i),
      .next_o(next_d)
   );

   bta_rel_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rel (
      .base_i(next_d),
      .off_i (operand_i[OFF_W-1:0]),
      .sum_o (rel_d)
   );

   bta_target_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_sel (
      .mode_i  (bta_mode_e'(mode_i)),
      .next_i  (next_d),
      .long_i  (operand_i),
      .rel_i   (rel_d),
      .target_o(tgt_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         next_q <= '0;
         tgt_q  <= '0;
      end else if (valid_i) begin
         next_q <= next_d;
         tgt_q  <= tgt_d;
      end
   end

   assign target_o = tgt_q;
   assign next_o   = next_q;
endmodule

// File: rtl/bta_target_gen_chk.sv
module bta_target_gen_chk #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 2,
   parameter int PAGE_W = 11,
   parameter int OFF_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              valid_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic [LEN_W-1:0]  len_i,
   input logic [1:0]        mode_i,
   input logic [ADDR_W-1:0] operand_i,
   input logic [ADDR_W-1:0] target_o,
   input logic [ADDR_W-1:0] next_o
);
   // R1
   reset_zero_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (target_o == '0 && next_o == '0));

   // R2 R9
   fallthru_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> next_o == ADDR_W'($past(pc_i) + ADDR_W'($past(len_i))));

   // R3
   long_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'd0) |=> target_o == $past(operand_i));

   // R4
   page_splice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'd1) |=>
         (target_o[PAGE_W-1:0] == $past(operand_i[PAGE_W-1:0]) &&
          target_o[ADDR_W-1:PAGE_W] == next_o[ADDR_W-1:PAGE_W]));

   // R5
   offset_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'd2) |=>
         ADDR_W'(target_o - next_o) == ADDR_W'($signed($past(operand_i[OFF_W-1:0]))));

   // R7
   reserved_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'd3) |=> target_o == next_o);

   // R8
   hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(target_o) && $stable(next_o)));
endmodule

bind bta_target_gen bta_target_gen_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .valid_i  (valid_i),
   .pc_i     (pc_i),
   .len_i    (len_i),
   .mode_i   (mode_i),
   .operand_i(operand_i),
   .target_o (target_o),
   .next_o   (next_o)
);

// File: tb/bta_target_gen_tb_top.sv
`timescale 1ns/1ps
module bta_target_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [15:0] pc = '0;
   logic [1:0]  len = 2'd1;
   logic [1:0]  mode = '0;
   logic [15:0] opnd = '0;
   logic [15:0] target;
   logic [15:0] nxt;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   bta_target_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .len_i(len),
      .mode_i(mode), .operand_i(opnd), .target_o(target), .next_o(nxt)
   );

   function automatic logic [15:0] exp_next(logic [15:0] p, logic [1:0] l);
      return p + {14'd0, l};
   endfunction

   function automatic logic [15:0] exp_tgt(logic [15:0] p, logic [1:0] l,
                                           logic [1:0] m, logic [15:0] o);
      logic [15:0] f;
      f = exp_next(p, l);
      case (m)
         2'd0:    return o;
         2'd1:    return {f[15:11], o[10:0]};
         2'd2:    return f + {{8{o[7]}}, o[7:0]};
         default: return f;
      endcase
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive on the falling edge, sample 1 ns after the capturing edge (R9).
   task automatic apply(string req, logic [15:0] p, logic [1:0] l,
                        logic [1:0] m, logic [15:0] o);
      @(negedge clk);
      valid = 1'b1; pc = p; len = l; mode = m; opnd = o;
      @(posedge clk);
      #1;
      check({req, " R2 next"}, nxt, exp_next(p, l));
      check({req, " target"}, target, exp_tgt(p, l, m, o));
   endtask

   initial begin
      #500000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] t_hold, n_hold;
      int unsigned seed;
      seed = $urandom(32'h5A17);
      repeat (3) @(posedge clk);
      #1;
      check("R1 target", target, 16'h0000);
      check("R1 next", nxt, 16'h0000);
      @(negedge clk) rst_n = 1'b1;

      apply("R3 long", 16'h1234, 2'd3, 2'd0, 16'hBEEF);
      apply("R4 page cross", 16'h07FE, 2'd3, 2'd1, 16'hF9A5);   // next 0801
      apply("R4 same page", 16'h3A10, 2'd2, 2'd1, 16'h0123);
      apply("R5 wrap up", 16'hFFFE, 2'd2, 2'd2, 16'h0005);       // 0005
      apply("R5 min offset", 16'h0000, 2'd2, 2'd2, 16'h0080);    // FF82
      apply("R5 max offset", 16'h4000, 2'd2, 2'd2, 16'h007F);
      apply("R6 rel junk hi", 16'h4000, 2'd2, 2'd2, 16'hAB7F);   // same as above
      apply("R6 page junk hi", 16'h07FE, 2'd3, 2'd1, 16'h01A5);
      apply("R7 reserved", 16'h2222, 2'd1, 2'd3, 16'h9999);
      apply("R2 top wrap", 16'hFFFF, 2'd1, 2'd0, 16'h0000);

      // R8: strobe low, new inputs must not reach the outputs.
      t_hold = target; n_hold = nxt;
      @(negedge clk);
      valid = 1'b0; pc = 16'h5555; len = 2'd3; mode = 2'd0; opnd = 16'h7777;
      repeat (2) @(posedge clk);
      #1;
      check("R8 target hold", target, t_hold);
      check("R8 next hold", nxt, n_hold);

      for (int i = 0; i < 400; i++) begin
         logic [1:0] l;
         l = 2'($urandom_range(1, 3));
         apply("R2-R7 random", 16'($urandom), l, 2'($urandom), 16'($urandom));
      end

      // R1: reset after activity clears both outputs.
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1 target again", target, 16'h0000);
      check("R1 next again", nxt, 16'h0000);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule